// File: doc/BRIEF.md
# Constant-Fraction Pulse Timing Extractor

This block takes one channel's digitized waveform as a framed sample stream and returns the arrival time of the pulse inside it. The time is an integer sample index plus an 8-bit binary fraction. The threshold is a programmable fraction of the pulse's own height above its baseline, so the reported time does not move when the pulse amplitude changes.

Samples arrive on a valid/ready stream. The first sample of a window carries a start marker and the last carries an end marker. The block buffers the window, subtracts a baseline averaged over the leading samples, and finds the highest sample. It then steps backward from that peak to the first earlier sample at or below the threshold. It interpolates linearly between that sample and its successor, using a sequential divider. Negative-going pulses are handled by inverting each sample on entry.

Input back-pressure works as follows. `in_ready` is high only while the block is collecting a window. It stays low from the cycle after the end marker is accepted until the result has been taken. The result is offered on a valid/ready output. A result waiting behind a low `out_ready` is held unchanged, and no new window is accepted until it leaves. Results that fail a check come out with `out_err` set instead of being dropped.

Top module: `cfd_timer`

## Requirements
- R1: A sample is taken only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is high exactly while a window is being collected. Samples taken with `in_sop`=0 while no window is open are discarded.
- R2: With `cfg_negative`=1, every sample s is replaced by (2^SW−1)−s before any further processing.
- R3: The baseline is the floor of the sum of the first N samples divided by N. `cfg_base_sel` selects N: 0 gives 4, 1 gives 8, 2 or 3 gives 16.
- R4: The peak is the largest sample in the window. If several samples share that value, the one with the lowest index is the peak.
- R5: The threshold is baseline + floor(k·amp/256). Here amp = peak − baseline, and k is `cfg_frac`, an unsigned fraction with 8 fractional bits.
- R6: The reported index i is the first index found walking down from peak−1 whose sample is at or below the threshold.
- R7: `out_frac` = floor(256·(thr − s[i]) / (s[i+1] − s[i])).
- R8: `out_err`=1 and `out_idx`=`out_frac`=0 in any of these cases: amp is 0, amp is below `cfg_min_amp`, the peak is at index 0, or no sample before the peak is at or below the threshold.
- R9: `out_err`=1 if the window holds fewer than N samples or more than DEPTH samples. A window of exactly DEPTH samples is valid.
- R10: While `out_valid`=1 and `out_ready`=0, all output fields stay stable and `in_ready` stays 0. After the handshake, `out_valid` drops and `in_ready` returns.
- R11: After reset, `out_valid`=0 and `in_ready`=1.
- R12: A sample with `in_sop`=1 arriving inside an open window discards that window and starts a new one at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample word present |
| in_ready | output | 1 | Block can take a sample |
| in_sop | input | 1 | First sample of a window |
| in_eop | input | 1 | Last sample of a window |
| in_data | input | SW | Unsigned sample code |
| cfg_negative | input | 1 | Pulses go negative; invert samples |
| cfg_base_sel | input | 2 | Baseline length select (4/8/16) |
| cfg_frac | input | KW | Constant fraction k, unsigned 0.KW |
| cfg_min_amp | input | SW | Smallest accepted amplitude |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_idx | output | log2(DEPTH) | Integer sample index of the crossing |
| out_frac | output | FW | Fractional position between idx and idx+1 |
| out_err | output | 1 | No valid timestamp for this window |

## Verification
The bench builds the block with SW=12, DEPTH=32, KW=8 and FW=8. A 32-deep buffer puts both the exact-depth window and the one-sample overflow within a few dozen cycles. Twelve-bit samples keep the inversion constant at 4095, and 32 slots leave room for a 16-sample baseline ahead of the pulse. With these values, randomized pulses with every baseline length and polarity fit in short windows, and all of them are compared against a behavioural queue-based model.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_EVAL,
    ST_WALK,
    ST_DIVIDE,
    ST_EMIT
  } cfd_state_e;

  // Number of leading samples averaged into the baseline.
  function automatic logic [4:0] base_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/cfd_capture.sv
module cfd_capture #(
  parameter int SW    = 12,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          sop,
  input  logic          eop,
  input  logic [SW-1:0] data,
  input  logic          negative,
  input  logic [1:0]    base_sel,
  output logic          win_end,
  output logic          short_win,
  output logic          overflow,
  output logic [SW-1:0] base,
  output logic [SW-1:0] peak,
  output logic [IW-1:0] peak_idx,
  input  logic [IW-1:0] rd_addr,
  output logic [SW-1:0] rd_data
);
  import cfd_pkg::*;

  localparam int CW   = IW + 1;
  localparam int SUMW = SW + 4;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [SW-1:0]   mem [DEPTH];
  logic [SW-1:0]   smp;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   nb;
  logic            open_q, ovf_q;
  logic [SUMW-1:0] sum_q;
  logic [SW-1:0]   peak_q;
  logic [IW-1:0]   pidx_q;
  logic            room;

  assign smp  = negative ? ~data : data;
  assign nb   = CW'(base_len(base_sel));
  assign room = (cnt_q < DEPTH_C);

  always_ff @(posedge clk) begin
    if (accept && sop)
      mem[0] <= smp;
    else if (accept && open_q && room)
      mem[cnt_q[IW-1:0]] <= smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
      sum_q  <= '0;
      peak_q <= '0;
      pidx_q <= '0;
    end else if (accept) begin
      if (sop) begin
        open_q <= !eop;
        ovf_q  <= 1'b0;
        cnt_q  <= CW'(1);
        sum_q  <= SUMW'(smp);
        peak_q <= smp;
        pidx_q <= '0;
      end else if (open_q) begin
        if (eop) open_q <= 1'b0;
        if (room) begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q < nb) sum_q <= sum_q + SUMW'(smp);
          if (smp > peak_q) begin
            peak_q <= smp;
            pidx_q <= cnt_q[IW-1:0];
          end
        end else begin
          ovf_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (base_sel)
      2'd0:    base = SW'(sum_q >> 2);
      2'd1:    base = SW'(sum_q >> 3);
      default: base = SW'(sum_q >> 4);
    endcase
  end

  assign win_end   = accept && eop && (sop || open_q);
  assign short_win = (cnt_q < nb);
  assign overflow  = ovf_q;
  assign peak      = peak_q;
  assign peak_idx  = pidx_q;
  assign rd_data   = mem[rd_addr];

endmodule

// File: rtl/cfd_divider.sv
module cfd_divider #(
  parameter int NW = 12,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          done,
  output logic [FW-1:0] quo
);
  localparam int SCW = $clog2(FW) + 1;

  logic [NW-1:0]  rem_q, den_q;
  logic [FW-1:0]  quo_q;
  logic [SCW-1:0] step_q;
  logic           busy_q, done_q;
  logic [NW:0]    shifted;
  logic           fits;

  assign shifted = {rem_q, 1'b0};
  assign fits    = (shifted >= {1'b0, den_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      rem_q  <= num;
      den_q  <= den;
      quo_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= fits ? NW'(shifted - {1'b0, den_q}) : shifted[NW-1:0];
      quo_q  <= {quo_q[FW-2:0], fits};
      step_q <= step_q + SCW'(1);
      if (step_q == SCW'(FW - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;

endmodule

// File: rtl/cfd_locator.sv
module cfd_locator #(
  parameter int SW    = 12,
  parameter int DEPTH = 64,
  parameter int KW    = 8,
  parameter int FW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_end,
  input  logic          short_win,
  input  logic          overflow,
  input  logic [SW-1:0] base,
  input  logic [SW-1:0] peak,
  input  logic [IW-1:0] peak_idx,
  input  logic [KW-1:0] frac_k,
  input  logic [SW-1:0] min_amp,
  output logic [IW-1:0] rd_addr,
  input  logic [SW-1:0] rd_data,
  output logic          div_start,
  output logic [SW-1:0] div_num,
  output logic [SW-1:0] div_den,
  input  logic          div_done,
  input  logic [FW-1:0] div_quo,
  output logic          collecting,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_idx,
  output logic [FW-1:0] out_frac,
  output logic          out_err
);
  import cfd_pkg::*;

  cfd_state_e       state_q;
  logic [IW-1:0]    idx_q;
  logic [SW-1:0]    thr_q, hi_q;
  logic [FW-1:0]    frac_q;
  logic             err_q;
  logic [SW-1:0]    amp;
  logic [SW+KW-1:0] prod;
  logic [SW-1:0]    thr;
  logic             eval_bad;
  logic             below;

  assign amp      = peak - base;
  assign prod     = (SW+KW)'(frac_k) * (SW+KW)'(amp);
  assign thr      = base + SW'(prod >> KW);
  assign eval_bad = short_win || overflow || (amp == '0) ||
                    (amp < min_amp) || (peak_idx == '0);
  assign below    = (rd_data <= thr_q);

  assign rd_addr   = idx_q;
  assign div_start = (state_q == ST_WALK) && below;
  assign div_num   = thr_q - rd_data;
  assign div_den   = hi_q - rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      idx_q   <= '0;
      thr_q   <= '0;
      hi_q    <= '0;
      frac_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_COLLECT: if (win_end) state_q <= ST_EVAL;
        ST_EVAL: begin
          thr_q <= thr;
          hi_q  <= peak;
          if (eval_bad) begin
            idx_q   <= '0;
            frac_q  <= '0;
            err_q   <= 1'b1;
            state_q <= ST_EMIT;
          end else begin
            idx_q   <= peak_idx - IW'(1);
            state_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (below) begin
            state_q <= ST_DIVIDE;
          end else if (idx_q == '0) begin
            frac_q  <= '0;
            err_q   <= 1'b1;
            state_q <= ST_EMIT;
          end else begin
            hi_q  <= rd_data;
            idx_q <= idx_q - IW'(1);
          end
        end
        ST_DIVIDE: begin
          if (div_done) begin
            frac_q  <= div_quo;
            err_q   <= 1'b0;
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: if (out_ready) state_q <= ST_COLLECT;
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign collecting = (state_q == ST_COLLECT);
  assign out_valid  = (state_q == ST_EMIT);
  assign out_idx    = idx_q;
  assign out_frac   = frac_q;
  assign out_err    = err_q;

endmodule

// File: rtl/cfd_timer.sv
module cfd_timer #(
  parameter int SW    = 12,
  parameter int DEPTH = 64,
  parameter int KW    = 8,
  parameter int FW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [SW-1:0] in_data,
  input  logic          cfg_negative,
  input  logic [1:0]    cfg_base_sel,
  input  logic [KW-1:0] cfg_frac,
  input  logic [SW-1:0] cfg_min_amp,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_idx,
  output logic [FW-1:0] out_frac,
  output logic          out_err
);
  logic          accept, win_end, short_win, overflow;
  logic [SW-1:0] base, peak, rd_data;
  logic [IW-1:0] peak_idx, rd_addr;
  logic          div_start, div_done;
  logic [SW-1:0] div_num, div_den;
  logic [FW-1:0] div_quo;
  logic          collecting;

  assign in_ready = collecting;
  assign accept   = in_valid && collecting;

  cfd_capture #(.SW(SW), .DEPTH(DEPTH)) u_capture (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sop(in_sop), .eop(in_eop),
    .data(in_data), .negative(cfg_negative), .base_sel(cfg_base_sel),
    .win_end(win_end), .short_win(short_win), .overflow(overflow),
    .base(base), .peak(peak), .peak_idx(peak_idx),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfd_locator #(.SW(SW), .DEPTH(DEPTH), .KW(KW), .FW(FW)) u_locator (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .short_win(short_win),
    .overflow(overflow), .base(base), .peak(peak), .peak_idx(peak_idx),
    .frac_k(cfg_frac), .min_amp(cfg_min_amp),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quo(div_quo),
    .collecting(collecting), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx), .out_frac(out_frac), .out_err(out_err)
  );

  cfd_divider #(.NW(SW), .FW(FW)) u_divider (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
    .den(div_den), .done(div_done), .quo(div_quo)
  );

endmodule

// File: rtl/cfd_timer_sva.sv
module cfd_timer_sva #(
  parameter int SW    = 12,
  parameter int DEPTH = 64,
  parameter int FW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_idx,
  input logic [FW-1:0] out_frac,
  input logic          out_err
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_idx) &&
                                $stable(out_frac) && $stable(out_err));

  assert_leave_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  assert_noaccept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_errzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> (out_idx == '0) && (out_frac == '0));

  // The crossing lies strictly before the peak, so the last slot is never reported.
  assert_before_peak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_idx != {IW{1'b1}});

endmodule

bind cfd_timer cfd_timer_sva #(.SW(SW), .DEPTH(DEPTH), .FW(FW)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_idx(out_idx), .out_frac(out_frac), .out_err(out_err)
);

// File: tb/cfd_timer_tb.sv
module cfd_timer_tb;
  localparam int SW = 12, DEPTH = 32, KW = 8, FW = 8;
  localparam int IW = $clog2(DEPTH);
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << SW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0;
  logic [SW-1:0] in_data = '0;
  logic cfg_negative = 0;
  logic [1:0] cfg_base_sel = 0;
  logic [KW-1:0] cfg_frac = 8'd59;
  logic [SW-1:0] cfg_min_amp = '0;
  logic in_ready, out_valid, out_err;
  logic [IW-1:0] out_idx;
  logic [FW-1:0] out_frac;

  int n_tests = 0, n_fail = 0;
  int st_data[$];
  bit st_sop[$], st_eop[$];
  int exp_idx, exp_frac;
  bit exp_err;
  bit prev_hold = 0;
  logic [IW-1:0] prev_idx;
  logic [FW-1:0] prev_frac;
  logic prev_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfd_timer #(.SW(SW), .DEPTH(DEPTH), .KW(KW), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .cfg_negative(cfg_negative), .cfg_base_sel(cfg_base_sel),
    .cfg_frac(cfg_frac), .cfg_min_amp(cfg_min_amp),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_frac(out_frac), .out_err(out_err)
  );

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-clock monitor: held results must not move, input must stay closed (R10).
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && in_ready) check("R10", "in_ready while result pending", 1, 0);
      if (prev_hold) begin
        check("R10", "held valid", int'(out_valid), 1);
        check("R10", "held idx", int'(out_idx), int'(prev_idx));
        check("R10", "held frac", int'(out_frac), int'(prev_frac));
        check("R10", "held err", int'(out_err), int'(prev_err));
      end
      prev_hold = out_valid && !out_ready;
      prev_idx = out_idx; prev_frac = out_frac; prev_err = out_err;
    end
  end

  task automatic add(int d, bit s, bit e);
    st_data.push_back(d); st_sop.push_back(s); st_eop.push_back(e);
  endtask

  task automatic add_pulse(int b, int a, int t0, int rise, int len);
    for (int j = 0; j < len; j++) begin
      int v;
      if (j < t0) v = b;
      else if (j < t0 + rise) v = b + (a * (j - t0 + 1)) / rise;
      else v = b + a / (2 + j - t0 - rise);
      add(v, j == 0, j == len - 1);
    end
  endtask

  // Behavioural reference built from the requirements.
  function automatic void model();
    int win[$];
    bit open = 0, ovf = 0;
    int n, sum, base, peak, pidx, amp, thr, i;
    for (int j = 0; j < st_data.size(); j++) begin
      int v;
      v = cfg_negative ? (MAXV - st_data[j]) : st_data[j];  // R2
      if (st_sop[j]) begin win.delete(); ovf = 0; open = 1; end  // R12
      if (open) begin
        if (win.size() < DEPTH) win.push_back(v); else ovf = 1;
        if (st_eop[j]) open = 0;
      end
    end
    exp_err = 1; exp_idx = 0; exp_frac = 0;
    n = (cfg_base_sel == 0) ? 4 : (cfg_base_sel == 1) ? 8 : 16;
    if (ovf || win.size() < n) return;  // R9
    sum = 0;
    for (int j = 0; j < n; j++) sum += win[j];
    base = sum / n;  // R3
    peak = win[0]; pidx = 0;
    for (int j = 1; j < win.size(); j++) if (win[j] > peak) begin peak = win[j]; pidx = j; end  // R4
    amp = peak - base;
    if (amp == 0 || amp < int'(cfg_min_amp)) return;  // R8
    thr = base + (int'(cfg_frac) * amp) / 256;  // R5
    for (i = pidx - 1; i >= 0; i--) if (win[i] <= thr) break;  // R6
    if (i < 0) return;
    exp_err = 0; exp_idx = i;
    exp_frac = ((thr - win[i]) * 256) / (win[i+1] - win[i]);  // R7
  endfunction

  task automatic send();
    for (int j = 0; j < st_data.size(); j++) begin
      @(negedge clk);
      in_valid = 1; in_data = SW'(st_data[j]); in_sop = st_sop[j]; in_eop = st_eop[j];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic run_case(string req, int stall);
    model();
    send();
    while (!out_valid) @(negedge clk);
    repeat (stall) @(negedge clk);
    check(req, "err", int'(out_err), int'(exp_err));
    check(req, "idx", int'(out_idx), exp_idx);
    check(req, "frac", int'(out_frac), exp_frac);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check("R10", "valid after handshake", int'(out_valid), 0);
    check("R1", "ready after handshake", int'(in_ready), 1);
    st_data.delete(); st_sop.delete(); st_eop.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R11", "in_ready after reset", int'(in_ready), 1);
    check("R11", "out_valid after reset", int'(out_valid), 0);

    // R5 R6 R7: basic positive pulse
    cfg_frac = 8'd59; cfg_min_amp = 12'd10;
    add_pulse(200, 1500, 6, 5, 24); run_case("R7", 0);
    // R2: same shape, negative going
    cfg_negative = 1;
    for (int j = 0; j < 24; j++) begin
      int v;
      v = (j < 6) ? 200 : (j < 11) ? 200 + (1500 * (j - 5)) / 5 : 200 + 1500 / (2 + j - 11);
      add(MAXV - v, j == 0, j == 23);
    end
    run_case("R2", 0);
    cfg_negative = 0;
    // R3: noisy baselines with 8 and 16 samples
    cfg_base_sel = 2'd1;
    for (int j = 0; j < 20; j++) add((j < 12) ? 190 + (j % 3) * 11 : 190 + 300 * (j - 11), j == 0, j == 19);
    run_case("R3", 0);
    cfg_base_sel = 2'd2;
    for (int j = 0; j < 28; j++) add((j < 18) ? 400 + (j % 5) * 7 : (j < 22) ? 400 + 700 * (j - 17) : 1500, j == 0, j == 27);
    run_case("R3", 0);
    cfg_base_sel = 2'd0;
    // R4: two equal maxima, earliest must win
    cfg_frac = 8'd128;
    foreach (st_data[j]) ;
    for (int j = 0; j < 4; j++) add(100, j == 0, 0);
    add(300, 0, 0); add(900, 0, 0); add(400, 0, 0); add(900, 0, 0); add(100, 0, 1);
    run_case("R4", 0);
    // R8: amplitude below minimum, flat window, peak at 0, no bracket
    cfg_frac = 8'd59; cfg_min_amp = 12'd100;
    add_pulse(300, 50, 5, 2, 12); run_case("R8", 0);
    cfg_min_amp = 12'd0;
    for (int j = 0; j < 10; j++) add(500, j == 0, j == 9);
    run_case("R8", 0);
    add(2000, 1, 0); for (int j = 1; j < 10; j++) add(100, 0, j == 9);
    run_case("R8", 0);
    add(900, 1, 0); add(1000, 0, 0); add(1100, 0, 0);
    for (int j = 3; j < 10; j++) add(50, 0, j == 9);
    run_case("R8", 0);
    // R9: too short, exactly full, one over
    add(10, 1, 0); add(900, 0, 0); add(20, 0, 1); run_case("R9", 0);
    add_pulse(100, 2000, 20, 4, DEPTH); run_case("R9", 0);
    add_pulse(100, 2000, 20, 4, DEPTH + 1); run_case("R9", 0);
    // R1: words before the start marker are dropped
    add(4000, 0, 0); add(3000, 0, 0); add(5, 0, 0);
    add_pulse(150, 1200, 5, 3, 14); run_case("R1", 0);
    // R12: start marker inside an open window restarts it
    for (int j = 0; j < 8; j++) add(3900 - 100 * j, j == 0, 0);
    add_pulse(250, 800, 7, 6, 18); run_case("R12", 0);
    // R10: stalled consumer
    add_pulse(120, 2500, 8, 4, 20); run_case("R10", 7);
    // R5: extreme fractions
    cfg_frac = 8'd0; add_pulse(300, 1000, 6, 5, 16); run_case("R5", 0);
    cfg_frac = 8'd255; add_pulse(300, 1000, 6, 5, 16); run_case("R5", 0);
    // R7: randomized pulses across polarity and baseline length
    for (int r = 0; r < 30; r++) begin
      int n, b, a, t0, rs;
      cfg_base_sel = 2'($urandom_range(0, 2));
      n = (cfg_base_sel == 0) ? 4 : (cfg_base_sel == 1) ? 8 : 16;
      cfg_frac = KW'($urandom_range(0, 255));
      cfg_negative = 1'($urandom_range(0, 1));
      b = $urandom_range(50, 400); a = $urandom_range(200, 3000);
      t0 = $urandom_range(n, 20); rs = $urandom_range(1, 6);
      add_pulse(b, a, t0, rs, t0 + rs + 4);
      if (cfg_negative) foreach (st_data[j]) st_data[j] = MAXV - st_data[j];
      run_case("R7", r % 3);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule